// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes four shared, active-high, level-sensitive PCI interrupt request inputs (A, B, C, D) and steers each onto one of sixteen legacy interrupt lines. Each request input has its own byte-wide steering register. When the byte holds a value from 0 to 15, the request drives the legacy line with that number. When it holds 16 or more, the request is switched off and drives nothing. A legacy line is asserted while any enabled request steered to it is asserted, so requests that share a line are ORed together.

The steering bytes are reached through a plain byte-addressed configuration port. Writes are strobed and reads are combinational. Because the port carries single configuration accesses and no data stream, it has no valid/ready handshake and never applies back-pressure: every strobed write is accepted in the cycle it is presented. For each request input the block also reports whether it is enabled and which line it targets. After any steering change, the whole request-to-line level matrix is rebuilt from the live request levels, so no line is left holding a stale level.

Top module: `pirq_router`

## Requirements
- R1: After reset, all four steering bytes read 0x80, `route_en_o` is 0, `route_line_o` is 0, and `irq_o` stays 0 whatever the request levels.
- R2: A write with `cfg_wr_en` high to offset 0x60, 0x61, 0x62 or 0x63 stores `cfg_wdata` into the steering byte of input A, B, C or D respectively. A read of that offset returns the whole stored byte, including the upper bits.
- R3: A write to any offset outside 0x60–0x63 changes no steering byte. A read of such an offset returns 0x00.
- R4: An input whose steering byte is 16 or more drives no legacy line, and it reports `route_en_o` bit 0 and a line field of 0.
- R5: An input whose steering byte is a value v below 16 drives `irq_o[v]` with its own level. The line follows a request change on the first rising clock edge that samples it.
- R6: When several enabled inputs are steered to the same line, that line is the OR of their levels.
- R7: After a steering write, every line reflects the new steering and the current request levels from the second rising edge after the write onward. A line that loses its only active source deasserts at that point.
- R8: For input i, `route_en_o[i]` is 1 and `route_line_o[4*i+3:4*i]` holds the target line while the byte is below 16. Both fields change on the same edge that stores the byte.
- R9: While `cfg_wr_en` is low, no steering byte or route status changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request levels, bit 0 = A ... bit 3 = D, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset, shared by reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| irq_o | output | 16 | Legacy interrupt lines, bit n = line n |
| route_en_o | output | 4 | Per-input enabled flag |
| route_line_o | output | 16 | Per-input target line, 4 bits per input, input A in bits 3:0 |

## Verification
The hardest case to reach from the ports is a request that stays asserted while its steering byte moves from one line to another, and then into the disabled range. The bench must show that the old line drops and the new one rises, with no leftover level in the matrix. To get there, the bench steers input A, holds its request high, and issues back-to-back steering writes. After each write it checks both the old and the new line two edges later. A shared-line scenario, in which several inputs feed one line and are released one at a time, shows that the OR does not drop while any source is still asserted.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef logic [7:0] cfg_byte_t;

  // A steering byte enables its input only when it names an existing line.
  function automatic logic route_is_live(input cfg_byte_t value, input int n_line);
    return int'(value) < n_line;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int CFG_AW   = 8,
  parameter int BASE_OFS = 'h60,
  parameter int RST_VAL  = 'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CFG_AW-1:0]    addr,
  input  cfg_byte_t            wdata,
  output cfg_byte_t            route_q [N_REQ],
  output cfg_byte_t            rdata
);

  logic [N_REQ-1:0] sel;

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_reg
    assign sel[gi] = (addr == CFG_AW'(BASE_OFS + gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[gi] <= cfg_byte_t'(RST_VAL);
      end else if (wr_en && sel[gi]) begin
        route_q[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (sel[i]) rdata = route_q[i];
    end
  end

endmodule

// File: rtl/pirq_route_decode.sv
module pirq_route_decode
  import pirq_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int N_LINE = 16,
  localparam int LINE_W = $clog2(N_LINE)
) (
  input  cfg_byte_t         route_q [N_REQ],
  output logic [N_REQ-1:0]  en,
  output logic [LINE_W-1:0] line [N_REQ]
);

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_dec
    assign en[gi]   = route_is_live(route_q[gi], N_LINE);
    assign line[gi] = en[gi] ? route_q[gi][LINE_W-1:0] : '0;
  end

endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix #(
  parameter int N_REQ  = 4,
  parameter int N_LINE = 16,
  localparam int LINE_W = $clog2(N_LINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  req,
  input  logic [N_REQ-1:0]  en,
  input  logic [LINE_W-1:0] line [N_REQ],
  output logic [N_REQ-1:0]  mat_q [N_LINE]
);

  logic [N_REQ-1:0] mat_d [N_LINE];

  // Whole matrix rebuilt each cycle from live levels and current steering.
  always_comb begin
    for (int l = 0; l < N_LINE; l++) begin
      for (int i = 0; i < N_REQ; i++) begin
        mat_d[l][i] = req[i] && en[i] && (line[i] == LINE_W'(l));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < N_LINE; l++) mat_q[l] <= '0;
    end else begin
      for (int l = 0; l < N_LINE; l++) mat_q[l] <= mat_d[l];
    end
  end

endmodule

// File: rtl/pirq_line_merge.sv
module pirq_line_merge #(
  parameter int N_REQ  = 4,
  parameter int N_LINE = 16
) (
  input  logic [N_REQ-1:0]  mat_q [N_LINE],
  output logic [N_LINE-1:0] irq
);

  for (genvar gl = 0; gl < N_LINE; gl++) begin : g_line
    assign irq[gl] = |mat_q[gl];
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int N_LINE   = 16,
  parameter int CFG_AW   = 8,
  parameter int BASE_OFS = 'h60,
  parameter int RST_VAL  = 'h80,
  localparam int LINE_W  = $clog2(N_LINE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_REQ-1:0]          req_i,
  input  logic                      cfg_wr_en,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  output logic [N_LINE-1:0]         irq_o,
  output logic [N_REQ-1:0]          route_en_o,
  output logic [N_REQ*LINE_W-1:0]   route_line_o
);

  cfg_byte_t         route_q [N_REQ];
  logic [N_REQ-1:0]  en;
  logic [LINE_W-1:0] line [N_REQ];
  logic [N_REQ-1:0]  mat_q [N_LINE];

  pirq_route_regs #(
    .N_REQ(N_REQ), .CFG_AW(CFG_AW), .BASE_OFS(BASE_OFS), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .route_q(route_q), .rdata(cfg_rdata)
  );

  pirq_route_decode #(.N_REQ(N_REQ), .N_LINE(N_LINE)) u_dec (
    .route_q(route_q), .en(en), .line(line)
  );

  pirq_level_matrix #(.N_REQ(N_REQ), .N_LINE(N_LINE)) u_mat (
    .clk(clk), .rst_n(rst_n), .req(req_i), .en(en), .line(line), .mat_q(mat_q)
  );

  pirq_line_merge #(.N_REQ(N_REQ), .N_LINE(N_LINE)) u_merge (
    .mat_q(mat_q), .irq(irq_o)
  );

  assign route_en_o = en;
  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_stat
    assign route_line_o[gi*LINE_W +: LINE_W] = line[gi];
  end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_REQ    = 4,
  parameter int N_LINE   = 16,
  parameter int CFG_AW   = 8,
  parameter int BASE_OFS = 'h60,
  localparam int LINE_W  = $clog2(N_LINE)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_i,
  input logic                    cfg_wr_en,
  input logic [CFG_AW-1:0]       cfg_addr,
  input logic [7:0]              cfg_wdata,
  input logic [7:0]              cfg_rdata,
  input logic [N_LINE-1:0]       irq_o,
  input logic [N_REQ-1:0]        route_en_o,
  input logic [N_REQ*LINE_W-1:0] route_line_o
);

  // Which lines the reported route status and live requests would drive.
  logic [N_LINE-1:0] hit;
  always_comb begin
    hit = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && route_en_o[i])
        hit[route_line_o[i*LINE_W +: LINE_W]] = 1'b1;
    end
  end

  logic outside;
  assign outside = (int'(cfg_addr) < BASE_OFS) || (int'(cfg_addr) >= BASE_OFS + N_REQ);

  for (genvar gl = 0; gl < N_LINE; gl++) begin : g_line
    // R5 / R6 / R7: each line is the registered OR of its steered sources
    a_r5_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o[gl] == $past(hit[gl])));
  end

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
    a_r4_disabled_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !route_en_o[gi] |-> (route_line_o[gi*LINE_W +: LINE_W] == '0));

    a_r8_status_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == CFG_AW'(BASE_OFS + gi)) |=>
        (route_en_o[gi] == (int'($past(cfg_wdata)) < N_LINE)));
  end

  a_r3_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (cfg_rdata == 8'h00));

  a_r9_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> ($stable(route_en_o) && $stable(route_line_o)));

endmodule

bind pirq_router pirq_router_chk #(
  .N_REQ(N_REQ), .N_LINE(N_LINE), .CFG_AW(CFG_AW), .BASE_OFS(BASE_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_wr_en(cfg_wr_en),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .irq_o(irq_o), .route_en_o(route_en_o), .route_line_o(route_line_o)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_i = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_o;
  logic [3:0]  route_en_o;
  logic [15:0] route_line_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_route [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o), .route_en_o(route_en_o), .route_line_o(route_line_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_irq(input logic [3:0] r);
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (r[i] && m_route[i] < 8'd16) v[m_route[i][3:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] exp_en();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_route[i] < 8'd16;
    return v;
  endfunction

  function automatic logic [15:0] exp_line();
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (m_route[i] < 8'd16) v[i*4 +: 4] = m_route[i][3:0];
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    tick();
    cfg_wr_en = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) m_route[a - 8'h60] = d;
  endtask

  task automatic cfg_rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic apply_req(input string req, input logic [3:0] r);
    req_i = r;
    tick();
    check(req, irq_o, exp_irq(r));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    for (int i = 0; i < 4; i++) cfg_rd_check("R1 reset byte", 8'(8'h60 + i), 8'h80);
    check("R1 route_en", route_en_o, 0);
    check("R1 route_line", route_line_o, 0);
    apply_req("R1 irq quiet with all requests", 4'hF);
    check("R1 irq zero", irq_o, 0);
    req_i = '0; tick();
  endtask

  task automatic t_write_read();
    cfg_wr(8'h60, 8'h05);
    cfg_wr(8'h61, 8'h0A);
    cfg_wr(8'h62, 8'h9E);
    cfg_wr(8'h63, 8'h0F);
    cfg_rd_check("R2 read A", 8'h60, 8'h05);
    cfg_rd_check("R2 read B", 8'h61, 8'h0A);
    cfg_rd_check("R2 read C upper bits", 8'h62, 8'h9E);
    cfg_rd_check("R2 read D", 8'h63, 8'h0F);
    check("R8 route_en", route_en_o, 4'b1011);
    check("R8 route_line", route_line_o, 16'hF0A5);
    check("R8 model status", route_line_o, exp_line());
  endtask

  task automatic t_ignore();
    cfg_wr(8'h5F, 8'h01);
    cfg_wr(8'h64, 8'h01);
    cfg_wr(8'hE0, 8'h01);
    for (int i = 0; i < 4; i++) cfg_rd_check("R3 bytes kept", 8'(8'h60 + i), m_route[i]);
    cfg_rd_check("R3 outside read 0x64", 8'h64, 8'h00);
    cfg_rd_check("R3 outside read 0x5F", 8'h5F, 8'h00);
    cfg_addr = 8'h60; cfg_wdata = 8'h03; cfg_wr_en = 1'b0;
    tick(); tick();
    cfg_rd_check("R9 no strobe byte kept", 8'h60, m_route[0]);
    check("R9 no strobe status", route_line_o, exp_line());
  endtask

  task automatic t_single();
    apply_req("R5 A to line 5", 4'b0001);
    check("R5 line 5 only", irq_o, 16'h0020);
    apply_req("R5 B to line 10", 4'b0010);
    apply_req("R4 C disabled", 4'b0100);
    check("R4 C drives nothing", irq_o, 0);
    apply_req("R5 D to line 15", 4'b1000);
    apply_req("R5 all", 4'b1111);
    check("R5 all lines", irq_o, 16'h8420);
    apply_req("R5 release", 4'b0000);
  endtask

  task automatic t_share();
    cfg_wr(8'h60, 8'h03);
    cfg_wr(8'h61, 8'h03);
    cfg_wr(8'h62, 8'h03);
    cfg_wr(8'h63, 8'h00);
    check("R8 shared status", route_line_o, 16'h0333);
    apply_req("R6 A alone", 4'b0001);
    apply_req("R6 B and C", 4'b0110);
    apply_req("R6 C only", 4'b0100);
    check("R6 line 3 held", irq_o, 16'h0008);
    apply_req("R6 D to line 0", 4'b1000);
    check("R6 line 0 boundary", irq_o, 16'h0001);
    apply_req("R6 release", 4'b0000);
  endtask

  task automatic t_reroute();
    apply_req("R7 A held on 3", 4'b0001);
    cfg_wr(8'h60, 8'h07);
    tick();
    check("R7 moved to line 7", irq_o, 16'h0080);
    cfg_wr(8'h60, 8'h10);
    check("R4 disabled status", route_en_o[0], 0);
    tick();
    check("R7 R4 disabled drops", irq_o, 16'h0000);
    cfg_wr(8'h60, 8'h0C);
    tick();
    check("R7 re-enabled line 12", irq_o, exp_irq(req_i));
    apply_req("R7 release", 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_ignore();
    t_single();
    t_share();
    t_reroute();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule